// File: doc/BRIEF.md
# Interval Footprint Priority Classifier

This block converts sampled working-set estimates into a discrete cache insertion priority for every application that shares a last-level cache. Each application has a set of sampling units, and each unit counts the distinct block addresses that application touched in one monitored cache set. The block counts miss events at the shared cache. When a fixed number of misses has been seen, it walks through the applications one at a time. For each one it adds the unique counts of all of its sampled sets and derives the average footprint. It then files the application into one of four priority classes and records both the class and the footprint in per-application storage.

Class boundaries are tuned for a 16-way cache. The average is never divided out for the classification. Instead, the raw sum is compared against each boundary multiplied by the number of sampled sets. For the stored footprint byte, a short bit-serial division produces the average in unsigned 4.4 fixed point. Once the last application has been written, a single-cycle clear pulse tells the samplers to start a fresh interval. Insertion logic in the cache reads the class of any application through a combinational read port.

Top module: `footprint_classifier`

## Requirements
- R1: After reset, every application reads priority code 1 (medium) and footprint byte 0, and the clear pulse is low.
- R2: An interval ends on the cycle in which `miss_i` is high for the INTERVAL-th time since reset or since the previous interval end. Cycles with `miss_i` low are not counted.
- R3: An application whose set-count sum is at most 3×NUM_SETS (average 0 to 3 inclusive) gets priority code 0 (high).
- R4: A sum above 3×NUM_SETS and at most 12×NUM_SETS (average above 3, up to 12) gets code 1 (medium).
- R5: A sum above 12×NUM_SETS and below 16×NUM_SETS (average above 12 and below 16) gets code 2 (low).
- R6: A sum of 16×NUM_SETS or more (average 16 or more) gets code 3 (least).
- R7: The stored footprint byte is floor(16×sum/NUM_SETS), which is the average in unsigned 4.4 fixed point, saturated to 255.
- R8: `clr_o` is high for exactly one cycle. It rises in the cycle after the last application's map update, which is the (10×NUM_APPS+1)-th cycle counting the cycle that follows the clock edge that sampled the terminal miss.
- R9: Between interval ends, changes on `set_counts_i` have no effect on the class or footprint read back for any application.
- R10: INTERVAL must exceed the scan length (10×NUM_APPS+1 cycles), so an interval never ends while a scan is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| miss_i | input | 1 | One pulse per last-level-cache miss |
| set_counts_i | input | NUM_APPS×NUM_SETS×CNT_W | Unique counts; application a, set s at bit offset (a×NUM_SETS+s)×CNT_W |
| rd_app_i | input | APP_W | Application selected on the read port |
| rd_prio_o | output | 2 | Priority code of the selected application |
| rd_fp_o | output | 8 | Footprint byte (4.4 fixed point) of the selected application |
| clr_o | output | 1 | One-cycle clear pulse to the samplers |

## Verification
Directed intervals place per-application sums exactly on and next to each class boundary: 3, 12 and 16 times the set count, and one more than those values. These intervals separate an off-by-one comparison from a correct one. They also include sums whose scaled footprint lands just under and over the 255 saturation point. Random intervals spread the counts over the whole range, with a non-power-of-two set count, so that truncation errors in the bit-serial division become visible. Each interval is driven with irregular gaps between misses. The bench measures the clear pulse's position and width, and the count inputs are scrambled in the middle of an interval to show that the stored map only changes at interval ends.

// File: rtl/footprint_classifier.sv
`timescale 1ns/1ps
module footprint_classifier #(
  parameter int NUM_APPS = 8,
  parameter int NUM_SETS = 40,
  parameter int CNT_W    = 5,
  parameter int INTERVAL = 1000000,
  localparam int APP_W   = (NUM_APPS > 1) ? $clog2(NUM_APPS) : 1,
  localparam int MISS_W  = $clog2(INTERVAL),
  localparam int SUM_W   = $clog2(NUM_SETS * ((1 << CNT_W) - 1) + 1),
  localparam int REM_W   = SUM_W + 12
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             miss_i,
  input  logic [NUM_APPS*NUM_SETS*CNT_W-1:0] set_counts_i,
  input  logic [APP_W-1:0]                 rd_app_i,
  output logic [1:0]                       rd_prio_o,
  output logic [7:0]                       rd_fp_o,
  output logic                             clr_o
);

  localparam int TH_HIGH = 3 * NUM_SETS;
  localparam int TH_MED  = 12 * NUM_SETS;
  localparam int TH_LOW  = 16 * NUM_SETS;

  typedef enum logic [2:0] {S_IDLE, S_LOAD, S_DIV, S_WRITE, S_CLR} state_t;

  state_t            state_q;
  logic [MISS_W-1:0] miss_cnt_q;
  logic [APP_W-1:0]  app_q;
  logic [2:0]        bit_q;
  logic [REM_W-1:0]  rem_q;
  logic [7:0]        quo_q;
  logic [1:0]        cls_q;
  logic              sat_q;
  logic [1:0]        prio_q [NUM_APPS];
  logic [7:0]        fp_q   [NUM_APPS];

  logic [SUM_W-1:0]  app_sum;
  logic [31:0]       sum32;
  logic [1:0]        cls_d;
  logic [REM_W-1:0]  div_step;
  logic              end_evt;

  assign end_evt  = miss_i && (miss_cnt_q == MISS_W'(INTERVAL - 1));
  assign sum32    = 32'(app_sum);
  assign div_step = REM_W'(NUM_SETS) << bit_q;
  assign clr_o    = (state_q == S_CLR);
  assign rd_prio_o = prio_q[rd_app_i];
  assign rd_fp_o   = fp_q[rd_app_i];

  always_comb begin
    app_sum = '0;
    for (int s = 0; s < NUM_SETS; s++)
      app_sum = app_sum + SUM_W'(set_counts_i[(int'(app_q) * NUM_SETS + s) * CNT_W +: CNT_W]);
  end

  always_comb begin
    if (sum32 <= TH_HIGH)      cls_d = 2'd0;
    else if (sum32 <= TH_MED)  cls_d = 2'd1;
    else if (sum32 < TH_LOW)   cls_d = 2'd2;
    else                       cls_d = 2'd3;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) miss_cnt_q <= '0;
    else if (end_evt) miss_cnt_q <= '0;
    else if (miss_i) miss_cnt_q <= miss_cnt_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      app_q   <= '0;
      bit_q   <= '0;
      rem_q   <= '0;
      quo_q   <= '0;
      cls_q   <= '0;
      sat_q   <= 1'b0;
      for (int a = 0; a < NUM_APPS; a++) begin
        prio_q[a] <= 2'd1;
        fp_q[a]   <= 8'd0;
      end
    end else begin
      case (state_q)
        S_IDLE: if (end_evt) begin
          state_q <= S_LOAD;
          app_q   <= '0;
        end
        S_LOAD: begin
          rem_q   <= REM_W'(app_sum) << 4;
          quo_q   <= '0;
          cls_q   <= cls_d;
          sat_q   <= (sum32 >= TH_LOW);
          bit_q   <= 3'd7;
          state_q <= S_DIV;
        end
        S_DIV: begin
          if (rem_q >= div_step) begin
            rem_q        <= rem_q - div_step;
            quo_q[bit_q] <= 1'b1;
          end
          if (bit_q == 3'd0) state_q <= S_WRITE;
          else bit_q <= bit_q - 1'b1;
        end
        S_WRITE: begin
          prio_q[app_q] <= cls_q;
          fp_q[app_q]   <= sat_q ? 8'hFF : quo_q;
          if (app_q == APP_W'(NUM_APPS - 1)) state_q <= S_CLR;
          else begin
            app_q   <= app_q + 1'b1;
            state_q <= S_LOAD;
          end
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assert_clr_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    clr_o |=> !clr_o);

  assert_clr_after_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(clr_o) |-> $past(state_q == S_WRITE));

  assert_no_end_while_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    end_evt |-> (state_q == S_IDLE));

  assert_map_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != S_WRITE) |=> ($stable(rd_app_i) -> ($stable(rd_prio_o) && $stable(rd_fp_o))));

  assert_high_fp_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_WRITE && cls_q == 2'd0) |-> (quo_q <= 8'd48));

  assert_least_saturates_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_WRITE && cls_q == 2'd3) |=> (fp_q[$past(app_q)] == 8'hFF));

endmodule

// File: tb/footprint_classifier_tb_top.sv
`timescale 1ns/1ps
module footprint_classifier_tb_top;
  localparam int NA = 4;
  localparam int NS = 5;
  localparam int CW = 5;
  localparam int IV = 64;
  localparam int AW = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic miss_i = 1'b0;
  logic [NA*NS*CW-1:0] counts = '0;
  logic [AW-1:0] rd_app = '0;
  logic [1:0] rd_prio;
  logic [7:0] rd_fp;
  logic clr;

  int vectors = 0;
  int fails = 0;
  int exp_prio [NA];
  int exp_fp [NA];
  int sums [NA];

  always #4 clk = ~clk;

  footprint_classifier #(.NUM_APPS(NA), .NUM_SETS(NS), .CNT_W(CW), .INTERVAL(IV)) dut_i (
    .clk(clk), .rst_n(rst_n), .miss_i(miss_i), .set_counts_i(counts),
    .rd_app_i(rd_app), .rd_prio_o(rd_prio), .rd_fp_o(rd_fp), .clr_o(clr));

  function automatic int model_prio(int s);
    if (s <= 3*NS) return 0;
    if (s <= 12*NS) return 1;
    if (s < 16*NS) return 2;
    return 3;
  endfunction

  function automatic int model_fp(int s);
    int q = (s * 16) / NS;
    return (q > 255) ? 255 : q;
  endfunction

  task automatic check(string req, int act, int expv, string what);
    vectors++;
    if (act != expv) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  task automatic load_counts(int scramble);
    for (int a = 0; a < NA; a++) begin
      int rest = sums[a];
      for (int s = 0; s < NS; s++) begin
        int v = (s == NS-1) ? rest : ((rest > 31) ? 31 : rest);
        if (scramble != 0) v = $urandom_range(31);
        counts[(a*NS+s)*CW +: CW] = CW'(v);
        if (scramble == 0) rest -= v;
      end
    end
  endtask

  task automatic read_all(string rq, string rf);
    for (int a = 0; a < NA; a++) begin
      @(negedge clk);
      rd_app = AW'(a);
      #1;
      check(rq, int'(rd_prio), exp_prio[a], $sformatf("prio app%0d", a));
      check(rf, int'(rd_fp), exp_fp[a], $sformatf("fp app%0d", a));
    end
  endtask

  task automatic run_interval();
    int seen_clr = 0;
    int k;
    load_counts(0);
    for (int m = 0; m < IV - 1; m++) begin
      int gap = $urandom_range(2);
      for (int g = 0; g < gap; g++) begin
        @(negedge clk); miss_i = 1'b0;
        if (clr) seen_clr++;
      end
      @(negedge clk); miss_i = 1'b1;
      if (clr) seen_clr++;
      if (m == IV/2) begin
        @(negedge clk); miss_i = 1'b0;
        load_counts(1);
        read_all("R9", "R9");
        load_counts(0);
      end
    end
    @(negedge clk); miss_i = 1'b0;
    for (int w = 0; w < 12*NA; w++) begin
      @(negedge clk);
      if (clr) seen_clr++;
    end
    check("R2", seen_clr, 0, "clear before terminal miss");
    @(negedge clk); miss_i = 1'b1;
    @(negedge clk); miss_i = 1'b0;
    k = 1;
    while (!clr && k < 1000) begin
      @(negedge clk); k++;
    end
    check("R8", k, 10*NA + 1, "cycles to clear pulse");
    @(negedge clk);
    check("R8", int'(clr), 0, "clear width");
    for (int a = 0; a < NA; a++) begin
      exp_prio[a] = model_prio(sums[a]);
      exp_fp[a] = model_fp(sums[a]);
    end
    read_all("R3/R4/R5/R6", "R7");
  endtask

  initial begin
    #(8 * 150000);
    fails++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd2718));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", int'(clr), 0, "clear after reset");
    for (int a = 0; a < NA; a++) begin exp_prio[a] = 1; exp_fp[a] = 0; end
    read_all("R1", "R1");

    // R3 R4 boundaries: 15 -> high, 16 -> medium, 60 -> medium, 61 -> low
    sums = '{15, 16, 60, 61};
    run_interval();
    // R5 R6 boundaries and R7 saturation
    sums = '{79, 80, 0, 155};
    run_interval();
    // R7 just under and at the 255 threshold: 79*16/5=252, 11 -> 35
    sums = '{11, 1, 14, 79};
    run_interval();
    for (int r = 0; r < 8; r++) begin
      for (int a = 0; a < NA; a++)
        sums[a] = ($urandom_range(3) == 0) ? $urandom_range(155) : $urandom_range(85);
      run_interval();
    end

    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule